// File: doc/BRIEF.md
# Self-Test Pattern and Signature Controller

This block wraps a small combinational circuit for built-in self-test. A maximal-length pattern register drives the circuit's inputs. On every clock edge after the active-low reset is released, it steps to its next state. The circuit's single response bit is folded into a serial-input signature register on the same edges. An edge counter stops both registers once every nonzero pattern has been applied exactly once. The signature then freezes and the block flags completion.

When the run completes, the block compares the final signature on-chip against a parameterised good value and drives a pass flag. For external comparison, a shift-out input rotates the signature one position per clock, lowest bit first, onto a serial pin. The circuit under test sits outside the block.

Top module: `bist_sig_ctrl`

## Requirements
- R1: While reset is low, the pattern output is 3'b100, the signature is 3'b000, and done, pass and the serial output are all 0.
- R2: Before done, each clock edge moves the pattern p to {p[1:0], p[2]^p[1]}. Starting from 3'b100, it visits all seven nonzero states and is back at 3'b100 when done rises.
- R3: Before done, each clock edge moves the signature s to {s[1:0], s[2]^s[1]^resp}, where resp is the response bit for the pattern present before that edge.
- R4: Done is low for the first six edges after reset release. It rises on the seventh edge and then stays high until the next reset.
- R5: After done, with shift-out low, the pattern and the signature hold their values.
- R6: Pass is 0 whenever done is 0. While done is 1, pass is 1 exactly when the final signature equals GOOD_SIG (default 3'b011).
- R7: After done, with shift-out high, each edge rotates the signature right by one position. The serial output always equals signature bit 0, so three edges present bits 0, 1, 2 and restore the signature.
- R8: Pass keeps its value while the signature is being rotated out.
- R9: Shift-out held high before done has no effect on the signature that is captured.
- R10: A constant-1 response and a constant-0 response both give signature 3'b000 and pass low.
- R11: Over all 256 three-input truth tables for the circuit under test, exactly 32 produce the good signature. Every one of them drives pass high, including faulty tables that alias to the good value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; seeds both registers and clears the counter |
| shift_en | input | 1 | After done, rotates the signature out serially |
| resp_i | input | 1 | Response bit from the circuit under test |
| pattern_o | output | W | Pattern register state driven to the circuit under test |
| done_o | output | 1 | Test sequence complete |
| pass_o | output | 1 | Signature matched GOOD_SIG (only while done) |
| sig_o | output | W | Signature register contents |
| sout_o | output | 1 | Serial signature bit (bit 0 of sig_o) |

## Verification
Every result is registered, so the bench drives inputs and releases reset on falling edges and reads outputs on the falling edge after each rising edge. Edge k after release therefore has its pattern, signature and done value visible half a cycle later. The bench compares done against k==7 and the signature against a software model advanced once per edge. Pass is captured on the same edge as done, so it is read together with done. During shift-out, each rotated bit is read one edge after the previous one, and pass is checked at each of those samples.

// File: rtl/bist_pkg.sv
package bist_pkg;
    typedef enum logic [0:0] {
        PH_RUN  = 1'b0,
        PH_DONE = 1'b1
    } bist_phase_e;
endpackage

// File: rtl/bist_pattern_gen.sv
module bist_pattern_gen #(
    parameter int          W    = 3,
    parameter logic [W-1:0] SEED = 3'b100,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state_o
);
    typedef struct packed {
        logic [W-1:0] st;
    } gen_t;

    gen_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (adv) begin
            r_d.st = {r_q.st[W-2:0], ^(r_q.st & TAPS)};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= SEED;
        else        r_q    <= r_d;
    end

    assign state_o = r_q.st;
endmodule

// File: rtl/bist_sig_reg.sv
module bist_sig_reg #(
    parameter int           W    = 3,
    parameter logic [W-1:0] SEED = '0,
    parameter logic [W-1:0] TAPS = 3'b110
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         absorb,
    input  logic         rotate,
    input  logic         din,
    output logic [W-1:0] sig_o,
    output logic [W-1:0] sig_next_o
);
    typedef struct packed {
        logic [W-1:0] sig;
    } sig_t;

    sig_t r_d, r_q;
    logic fold_bit;

    always_comb begin
        fold_bit = (^(r_q.sig & TAPS)) ^ din;
        r_d      = r_q;
        if (absorb) begin
            r_d.sig = {r_q.sig[W-2:0], fold_bit};
        end else if (rotate) begin
            r_d.sig = {r_q.sig[0], r_q.sig[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.sig <= SEED;
        else        r_q     <= r_d;
    end

    assign sig_o      = r_q.sig;
    assign sig_next_o = r_d.sig;
endmodule

// File: rtl/bist_seq_ctrl.sv
module bist_seq_ctrl
    import bist_pkg::*;
#(
    parameter int           W        = 3,
    parameter int           LEN      = 7,
    parameter logic [W-1:0] GOOD_SIG = 3'b011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] sig_next_i,
    output logic         run_o,
    output logic         rotate_o,
    output logic         done_o,
    output logic         pass_o
);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    typedef struct packed {
        bist_phase_e  ph;
        logic [W-1:0] cnt;
        logic         match;
    } ctl_t;

    ctl_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        run_o    = 1'b0;
        rotate_o = 1'b0;
        unique case (r_q.ph)
            PH_RUN: begin
                run_o     = 1'b1;
                r_d.cnt   = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.ph    = PH_DONE;
                    r_d.match = (sig_next_i == GOOD_SIG);
                end
            end
            PH_DONE: begin
                rotate_o = shift_en;
            end
            default: r_d.ph = PH_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ph    <= PH_RUN;
            r_q.cnt   <= '0;
            r_q.match <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o = (r_q.ph == PH_DONE);
    assign pass_o = done_o & r_q.match;
endmodule

// File: rtl/bist_sig_ctrl.sv
module bist_sig_ctrl #(
    parameter int           W        = 3,
    parameter logic [W-1:0] PAT_SEED = 3'b100,
    parameter logic [W-1:0] PAT_TAPS = 3'b110,
    parameter logic [W-1:0] SIG_TAPS = 3'b110,
    parameter logic [W-1:0] GOOD_SIG = 3'b011
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         resp_i,
    output logic [W-1:0] pattern_o,
    output logic         done_o,
    output logic         pass_o,
    output logic [W-1:0] sig_o,
    output logic         sout_o
);
    localparam int LEN = (1 << W) - 1;

    logic         run;
    logic         rotate;
    logic [W-1:0] sig_next;

    bist_pattern_gen #(.W(W), .SEED(PAT_SEED), .TAPS(PAT_TAPS)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (run),
        .state_o (pattern_o)
    );

    bist_sig_reg #(.W(W), .SEED('0), .TAPS(SIG_TAPS)) u_sig (
        .clk        (clk),
        .rst_n      (rst_n),
        .absorb     (run),
        .rotate     (rotate),
        .din        (resp_i),
        .sig_o      (sig_o),
        .sig_next_o (sig_next)
    );

    bist_seq_ctrl #(.W(W), .LEN(LEN), .GOOD_SIG(GOOD_SIG)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en   (shift_en),
        .sig_next_i (sig_next),
        .run_o      (run),
        .rotate_o   (rotate),
        .done_o     (done_o),
        .pass_o     (pass_o)
    );

    assign sout_o = sig_o[0];
endmodule

// File: rtl/bist_sig_ctrl_chk.sv
module bist_sig_ctrl_chk #(
    parameter int           W        = 3,
    parameter logic [W-1:0] PAT_TAPS = 3'b110,
    parameter logic [W-1:0] SIG_TAPS = 3'b110
) (
    input logic         clk,
    input logic         rst_n,
    input logic         shift_en,
    input logic         resp_i,
    input logic [W-1:0] pattern_o,
    input logic         done_o,
    input logic         pass_o,
    input logic [W-1:0] sig_o
);
    localparam int LEN = (1 << W) - 1;

    logic [W:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              edges_q <= '0;
        else if (edges_q < LEN)  edges_q <= edges_q + 1'b1;
    end

    p_pat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> pattern_o == {$past(pattern_o[W-2:0]), ^($past(pattern_o) & PAT_TAPS)});

    p_sig_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> sig_o == {$past(sig_o[W-2:0]), (^($past(sig_o) & SIG_TAPS)) ^ $past(resp_i)});

    p_done_time_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o == (edges_q == (W+1)'(LEN)));

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !shift_en |=> $stable(sig_o) && $stable(pattern_o));

    p_pass_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !pass_o);

    p_rotate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && shift_en |=> sig_o == {$past(sig_o[0]), $past(sig_o[W-1:1])});

    p_pass_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(pass_o));
endmodule

bind bist_sig_ctrl bist_sig_ctrl_chk #(.W(W), .PAT_TAPS(PAT_TAPS), .SIG_TAPS(SIG_TAPS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .resp_i    (resp_i),
    .pattern_o (pattern_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .sig_o     (sig_o)
);

// File: tb/bist_sig_ctrl_test.sv
`timescale 1ns/1ps
module bist_sig_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shift_en = 1'b0;
    logic [7:0] tt_q = 8'h00;
    logic       resp;
    logic [2:0] pattern;
    logic       done, pass, sout;
    logic [2:0] sig;

    int total = 0;
    int bad = 0;
    int alias_cnt = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    assign resp = tt_q[pattern];

    bist_sig_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .resp_i    (resp),
        .pattern_o (pattern),
        .done_o    (done),
        .pass_o    (pass),
        .sig_o     (sig),
        .sout_o    (sout)
    );

    function automatic logic [2:0] pstep(input logic [2:0] p);
        return {p[1:0], p[2] ^ p[1]};
    endfunction

    function automatic logic [2:0] sstep(input logic [2:0] s, input logic b);
        return {s[1:0], s[2] ^ s[1] ^ b};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [7:0] tt, input logic early_shift);
        logic [2:0] mp, ms, rot;
        int bad_seq, bad_sig, bad_done, bad_gate;
        bad_seq = 0; bad_sig = 0; bad_done = 0; bad_gate = 0;
        tt_q = tt;
        shift_en = early_shift;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pattern == 3'b100 && sig == 3'b000 && !done && !pass && !sout, "R1 reset",
            {pattern, sig}, {3'b100, 3'b000});
        rst_n = 1'b1;
        mp = 3'b100; ms = 3'b000;
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk); @(negedge clk);
            ms = sstep(ms, tt[mp]);
            mp = pstep(mp);
            if (pattern != mp) bad_seq++;
            if (sig != ms) bad_sig++;
            if (done != (k == 7)) bad_done++;
            if (k < 7 && pass) bad_gate++;
        end
        chk(bad_seq == 0, "R2 pattern sequence", bad_seq, 0);
        chk(pattern == 3'b100, "R2 back at seed", pattern, 3'b100);
        chk(bad_sig == 0, early_shift ? "R3 R9 signature" : "R3 signature", sig, ms);
        chk(bad_done == 0, "R4 done on seventh edge", bad_done, 0);
        chk(bad_gate == 0, "R6 pass gated by done", bad_gate, 0);
        chk(pass == (ms == 3'b011), "R6 pass value", pass, ms == 3'b011);
        if (tt == 8'hFF || tt == 8'h00)
            chk(sig == 3'b000 && !pass, "R10 constant response", sig, 0);
        if (ms == 3'b011 && !early_shift) alias_cnt++;
        if (early_shift) begin
            rot = ms;
            for (int r = 0; r < 3; r++) begin
                chk(sout == ms[r], "R7 serial bit", sout, ms[r]);
                @(posedge clk); @(negedge clk);
                rot = {rot[0], rot[2:1]};
                chk(sig == rot, "R7 rotate", sig, rot);
                chk(pass == (ms == 3'b011) && done, "R8 pass during shift", pass, ms == 3'b011);
            end
            chk(sig == ms, "R7 restored", sig, ms);
        end else begin
            repeat (3) begin @(posedge clk); @(negedge clk); end
            chk(sig == ms && pattern == 3'b100, "R5 hold", {pattern, sig}, {3'b100, ms});
            chk(done, "R4 done sticky", done, 1);
        end
    endtask

    initial begin
        for (int t = 0; t < 256; t++) begin
            run_one(8'(t), 1'b0);
            run_one(8'(t), 1'b1);
        end
        chk(alias_cnt == 32, "R11 tables giving good signature", alias_cnt, 32);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule